// File: doc/BRIEF.md
# Auto-Ranging Resistance Test Sequencer

This block sequences one surface-resistance measurement for an electrostatic-discharge meter. An external converter continuously presents the resistance as a decade value (the base-10 exponent of the reading) and an open-circuit flag. After a start strobe the sequencer selects the low test voltage (10 V) and holds it for an electrification period. It then requests a sample. If that reading is high or open, it switches to the high test voltage (100 V) and applies an identical period before taking the final reading.

The final reading is sorted into a material class. The class code and the voltage that produced it are reported with a one-cycle done pulse. Both stay held until the next start. The test voltage is switched off whenever no measurement runs.

Two period lengths are available. Compliance mode uses a fixed 15-second period. Quick mode uses a period of 2 to 5 seconds taken from an input. Seconds are counted by a parameterised cycle prescaler.

Top module: `rtest_seq`

## Requirements
- R1: While reset is low, and after it is released, drive_sel_o is 0 (off), class_o is 0 (no result), volt_o is 0, done_o is 0 and sample_o is 0.
- R2: A start accepted while idle selects the low voltage (drive_sel_o = 1) from the next cycle on. At that moment class_o and volt_o clear to 0.
- R3: Each voltage step lasts exactly SECS × CYC_PER_SEC cycles. SECS is 15 when quick_i = 0. When quick_i = 1, SECS is quick_secs_i clamped into 2..5. Mode and seconds are captured at start.
- R4: At the end of the low step, a decade of 6 or more, or open_i = 1, starts the high step (drive_sel_o = 2) with the same length. Otherwise the result is final with volt_o = 1. A result from the high step has volt_o = 2.
- R5: Decade d means a resistance in [10^d, 10^(d+1)). The final reading is classified as follows: d < 3 gives code 1 (short); 3..5 gives 2 (conductive); 6..10 gives 3 (dissipative); 11 gives 4 (indeterminate); 12 or more, or open_i = 1, gives 5 (insulative).
- R6: done_o is a one-cycle pulse in the cycle after the final sample. class_o and volt_o keep their values from that cycle until the next accepted start.
- R7: A start strobe, and any change of quick_i or quick_secs_i, during a measurement has no effect on its timing or result.
- R8: drive_sel_o returns to 0 in the cycle done_o is high and stays 0 until the next start.
- R9: sample_o is a one-cycle pulse in the last cycle of each step. The decade and open inputs are captured in that cycle. A measurement produces one pulse, or two pulses when it escalates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe |
| quick_i | input | 1 | 1 = quick mode, 0 = compliance mode |
| quick_secs_i | input | 3 | Quick-mode period in seconds (clamped to 2..5) |
| decade_i | input | 4 | Resistance decade from the converter |
| open_i | input | 1 | Converter reports open circuit |
| drive_sel_o | output | 2 | Test voltage: 0 off, 1 low, 2 high |
| sample_o | output | 1 | Reading captured this cycle |
| class_o | output | 3 | Material class code |
| volt_o | output | 2 | Voltage of the final reading: 1 low, 2 high |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench builds the block with CYC_PER_SEC = 4 and keeps the 15-second compliance period, the 2..5 quick range and the escalation decade at their defaults. A compliance step is then 60 cycles and a quick step is 8 to 20 cycles. Every period length, both clamp ends and the escalation into a second step can therefore be timed to the exact cycle. The 60-cycle steps still keep the prescaler and second counter distinct. With a one-second prescaler of a real clock, none of this would be reachable.

// File: rtl/rseq_pkg.sv
// Shared encodings for the resistance test sequencer.
// Assumes: drive and class codes are the port-level encodings of the top.
package rseq_pkg;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_LO  = 2'd1,
        DRV_HI  = 2'd2
    } drive_e;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_SHORT = 3'd1,
        CLS_COND  = 3'd2,
        CLS_DISS  = 3'd3,
        CLS_INDET = 3'd4,
        CLS_INSUL = 3'd5
    } class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } state_e;

endpackage

// File: rtl/rseq_timer.sv
// Electrification period timer.
// Counts CYC_PER_SEC cycles per second and flags the last cycle of a period
// of secs_i seconds. Assumes secs_i >= 1 and stays constant while run_i is high.
module rseq_timer #(
    parameter int CYC_PER_SEC = 1000000,
    parameter int SEC_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [SEC_W-1:0] secs_i,
    output logic             expire_o
);
    localparam int CYC_W = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_SEC - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [SEC_W-1:0] sec_q;
    logic             last_cyc;

    // Last cycle of the current second and of the whole period.
    always_comb begin
        last_cyc = (cyc_q == CYC_LAST);
        expire_o = run_i && last_cyc && (sec_q == (secs_i - SEC_W'(1)));
    end

    // Prescaler and seconds counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cyc_q <= '0;
            sec_q <= '0;
        end else if (run_i) begin
            if (last_cyc) begin
                cyc_q <= '0;
                sec_q <= sec_q + SEC_W'(1);
            end else begin
                cyc_q <= cyc_q + CYC_W'(1);
            end
        end
    end
endmodule

// File: rtl/rseq_classify.sv
// Reading classifier.
// Maps a decade and open flag to a class code and decides escalation on the
// low-voltage step. Purely combinational.
module rseq_classify
    import rseq_pkg::*;
#(
    parameter int DEC_W     = 4,
    parameter int SHORT_LIM = 3,
    parameter int DISS_LIM  = 6,
    parameter int INDET_DEC = 11,
    parameter int INSUL_LIM = 12
) (
    input  logic [DEC_W-1:0] decade_i,
    input  logic             open_i,
    input  logic             step_hi_i,
    output class_e           class_o,
    output logic             esc_o
);
    // Class bands on the decade; an open circuit reads as insulative.
    always_comb begin
        if (open_i)                                  class_o = CLS_INSUL;
        else if (decade_i < DEC_W'(SHORT_LIM))       class_o = CLS_SHORT;
        else if (decade_i < DEC_W'(DISS_LIM))        class_o = CLS_COND;
        else if (decade_i < DEC_W'(INDET_DEC))       class_o = CLS_DISS;
        else if (decade_i < DEC_W'(INSUL_LIM))       class_o = CLS_INDET;
        else                                         class_o = CLS_INSUL;
    end

    // Escalate only from the low step, on a high or open reading.
    always_comb esc_o = !step_hi_i && (open_i || (decade_i >= DEC_W'(DISS_LIM)));
endmodule

// File: rtl/rseq_ctrl.sv
// Measurement sequencer state machine.
// Runs low step, optional high step, then registers class, voltage and done.
// Assumes expire_i marks the last cycle of a step and the reading is valid then.
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int SEC_W     = 4,
    parameter int SECS_FULL = 15,
    parameter int SECS_MIN  = 2,
    parameter int SECS_MAX  = 5,
    parameter int QS_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             quick_i,
    input  logic [QS_W-1:0]  quick_secs_i,
    input  logic             expire_i,
    input  logic             esc_i,
    input  class_e           class_i,
    output logic             clear_o,
    output logic             run_o,
    output logic             step_hi_o,
    output logic [SEC_W-1:0] secs_o,
    output drive_e           drive_o,
    output logic             sample_o,
    output class_e           class_o,
    output drive_e           volt_o,
    output logic             done_o
);
    state_e           state_q;
    logic [SEC_W-1:0] secs_sel;
    logic             start_acc;

    // Period selected at start: fixed, or quick value clamped into range.
    always_comb begin
        if (!quick_i)                                secs_sel = SEC_W'(SECS_FULL);
        else if (quick_secs_i < QS_W'(SECS_MIN))     secs_sel = SEC_W'(SECS_MIN);
        else if (quick_secs_i > QS_W'(SECS_MAX))     secs_sel = SEC_W'(SECS_MAX);
        else                                         secs_sel = SEC_W'(quick_secs_i);
    end

    // Decoded controls toward the timer, classifier and ports.
    always_comb begin
        start_acc = start_i && (state_q == ST_IDLE);
        run_o     = (state_q != ST_IDLE);
        step_hi_o = (state_q == ST_HIGH);
        clear_o   = start_acc || expire_i;
        sample_o  = expire_i;
        case (state_q)
            ST_LOW:  drive_o = DRV_LO;
            ST_HIGH: drive_o = DRV_HI;
            default: drive_o = DRV_OFF;
        endcase
    end

    // Step sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            secs_o  <= '0;
            class_o <= CLS_NONE;
            volt_o  <= DRV_OFF;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_LOW;
                    secs_o  <= secs_sel;
                    class_o <= CLS_NONE;
                    volt_o  <= DRV_OFF;
                end
                ST_LOW: if (expire_i) begin
                    if (esc_i) begin
                        state_q <= ST_HIGH;
                    end else begin
                        state_q <= ST_IDLE;
                        class_o <= class_i;
                        volt_o  <= DRV_LO;
                        done_o  <= 1'b1;
                    end
                end
                ST_HIGH: if (expire_i) begin
                    state_q <= ST_IDLE;
                    class_o <= class_i;
                    volt_o  <= DRV_HI;
                    done_o  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rtest_seq.sv
// Auto-ranging resistance test sequencer, top level.
// Connects the period timer, classifier and step controller.
// Assumes decade_i/open_i track the converter and are stable in sample cycles.
module rtest_seq
    import rseq_pkg::*;
#(
    parameter int CYC_PER_SEC = 1000000,
    parameter int SECS_FULL   = 15,
    parameter int SECS_MIN    = 2,
    parameter int SECS_MAX    = 5,
    parameter int DEC_W       = 4,
    parameter int QS_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             quick_i,
    input  logic [QS_W-1:0]  quick_secs_i,
    input  logic [DEC_W-1:0] decade_i,
    input  logic             open_i,
    output logic [1:0]       drive_sel_o,
    output logic             sample_o,
    output logic [2:0]       class_o,
    output logic [1:0]       volt_o,
    output logic             done_o
);
    localparam int SEC_W = $clog2(SECS_FULL + 1);

    logic             clear, run, step_hi, expire, esc;
    logic [SEC_W-1:0] secs;
    class_e           cls_now, cls_reg;
    drive_e           drive, volt;

    rseq_timer #(.CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .run_i(run),
        .secs_i(secs), .expire_o(expire)
    );

    rseq_classify #(.DEC_W(DEC_W)) u_cls (
        .decade_i(decade_i), .open_i(open_i), .step_hi_i(step_hi),
        .class_o(cls_now), .esc_o(esc)
    );

    rseq_ctrl #(
        .SEC_W(SEC_W), .SECS_FULL(SECS_FULL), .SECS_MIN(SECS_MIN),
        .SECS_MAX(SECS_MAX), .QS_W(QS_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .quick_i(quick_i),
        .quick_secs_i(quick_secs_i), .expire_i(expire), .esc_i(esc),
        .class_i(cls_now), .clear_o(clear), .run_o(run), .step_hi_o(step_hi),
        .secs_o(secs), .drive_o(drive), .sample_o(sample_o),
        .class_o(cls_reg), .volt_o(volt), .done_o(done_o)
    );

    // Port-level encodings of the typed internal results.
    always_comb begin
        drive_sel_o = drive;
        class_o     = cls_reg;
        volt_o      = volt;
    end
endmodule

// File: rtl/rtest_seq_checker.sv
// Protocol checker for rtest_seq, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module rtest_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] drive_sel_o,
    input logic       sample_o,
    input logic [2:0] class_o,
    input logic       done_o
);
    // R8: no test voltage while the result is announced.
    p_off_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> drive_sel_o == 2'd0);

    // R6: done lasts one cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done follows a sample by one cycle.
    p_done_after_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sample_o));

    // R6: class changes only when a result lands or a start is taken.
    p_class_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(class_o) |-> (done_o || $past(start_i)));

    // R4: high voltage is entered only from the low step after a sample.
    p_high_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_sel_o == 2'd2 && $past(drive_sel_o) != 2'd2)
            |-> ($past(drive_sel_o) == 2'd1 && $past(sample_o)));

    // R9: samples happen only while a voltage is applied.
    p_sample_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> drive_sel_o != 2'd0);

    // R9: sample is a single-cycle pulse.
    p_sample_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
endmodule

bind rtest_seq rtest_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .drive_sel_o(drive_sel_o),
    .sample_o(sample_o), .class_o(class_o), .done_o(done_o)
);

// File: tb/rtest_seq_test.sv
`timescale 1ns/1ps
module rtest_seq_test;
    localparam int CPS = 4;

    typedef struct packed {
        logic       q;
        logic [2:0] qs;
        logic [3:0] dl;
        logic       ol;
        logic [3:0] dh;
        logic       oh;
        logic [2:0] ecls;
        logic [1:0] evolt;
        logic [7:0] n;
    } vec_t;

    // quick, secs, low reading, high reading, expected class, volt, step cycles
    localparam vec_t VECS [13] = '{
        '{1'b0, 3'd0, 4'd4,  1'b0, 4'd0,  1'b0, 3'd2, 2'd1, 8'd60},
        '{1'b1, 3'd3, 4'd2,  1'b0, 4'd0,  1'b0, 3'd1, 2'd1, 8'd12},
        '{1'b1, 3'd5, 4'd0,  1'b0, 4'd0,  1'b0, 3'd1, 2'd1, 8'd20},
        '{1'b1, 3'd2, 4'd5,  1'b0, 4'd0,  1'b0, 3'd2, 2'd1, 8'd8},
        '{1'b1, 3'd2, 4'd6,  1'b0, 4'd8,  1'b0, 3'd3, 2'd2, 8'd8},
        '{1'b1, 3'd3, 4'd1,  1'b1, 4'd11, 1'b0, 3'd4, 2'd2, 8'd12},
        '{1'b1, 3'd4, 4'd9,  1'b0, 4'd13, 1'b0, 3'd5, 2'd2, 8'd16},
        '{1'b1, 3'd2, 4'd7,  1'b0, 4'd3,  1'b1, 3'd5, 2'd2, 8'd8},
        '{1'b1, 3'd1, 4'd3,  1'b0, 4'd0,  1'b0, 3'd2, 2'd1, 8'd8},
        '{1'b1, 3'd7, 4'd12, 1'b0, 4'd5,  1'b0, 3'd2, 2'd2, 8'd20},
        '{1'b0, 3'd2, 4'd10, 1'b0, 4'd10, 1'b0, 3'd3, 2'd2, 8'd60},
        '{1'b1, 3'd0, 4'd12, 1'b0, 4'd12, 1'b0, 3'd5, 2'd2, 8'd8},
        '{1'b1, 3'd6, 4'd15, 1'b0, 4'd2,  1'b0, 3'd1, 2'd2, 8'd20}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       quick_i = 1'b0;
    logic [2:0] quick_secs_i = '0;
    logic [3:0] decade_i = '0;
    logic       open_i = 1'b0;
    logic [1:0] drive_sel_o;
    logic       sample_o;
    logic [2:0] class_o;
    logic [1:0] volt_o;
    logic       done_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rtest_seq #(.CYC_PER_SEC(CPS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .quick_i(quick_i),
        .quick_secs_i(quick_secs_i), .decade_i(decade_i), .open_i(open_i),
        .drive_sel_o(drive_sel_o), .sample_o(sample_o), .class_o(class_o),
        .volt_o(volt_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One measurement; poke injects a start and mode change mid-run (R7).
    task automatic run_one(input vec_t v, input bit poke);
        int k, first_k, done_k, samples;
        bit esc;
        esc = (v.dl >= 4'd6) || v.ol;
        first_k = 0; done_k = 0; samples = 0;
        @(negedge clk);
        quick_i = v.q; quick_secs_i = v.qs; decade_i = v.dl; open_i = v.ol;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(drive_sel_o == 2'd1, "R2 low drive first", drive_sel_o, 1);
        chk(class_o == 3'd0 && volt_o == 2'd0, "R2 result cleared", class_o, 0);
        for (k = 1; k < 400; k++) begin
            if (poke && k == 5) begin
                start_i = 1'b1; quick_i = ~v.q; quick_secs_i = 3'd2;
            end
            if (poke && k == 6) start_i = 1'b0;
            if (k == v.n + 1)
                chk(drive_sel_o == (esc ? 2'd2 : 2'd0), "R4 drive after low step",
                    drive_sel_o, esc ? 2 : 0);
            if (sample_o) begin
                samples++;
                if (first_k == 0) first_k = k;
            end
            if (done_o) begin
                done_k = k;
                break;
            end
            if (first_k != 0 && k == first_k + 1) begin
                decade_i = v.dh; open_i = v.oh;
            end
            @(negedge clk);
        end
        chk(first_k == v.n, "R3 first sample cycle", first_k, v.n);
        chk(done_k == (esc ? 2 * v.n + 1 : v.n + 1), poke ? "R7 done cycle" : "R3 done cycle",
            done_k, esc ? 2 * v.n + 1 : v.n + 1);
        chk(class_o == v.ecls, poke ? "R7 class" : "R5 class", class_o, v.ecls);
        chk(volt_o == v.evolt, "R4 voltage used", volt_o, v.evolt);
        chk(samples == (esc ? 2 : 1), "R9 sample count", samples, esc ? 2 : 1);
        chk(drive_sel_o == 2'd0, "R8 drive off at done", drive_sel_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done single cycle", done_o, 0);
        chk(class_o == v.ecls && drive_sel_o == 2'd0, "R6 R8 result held, drive off",
            class_o, v.ecls);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        vec_t pv;
        repeat (3) @(negedge clk);
        chk(drive_sel_o == 2'd0 && done_o == 1'b0 && sample_o == 1'b0,
            "R1 outputs idle in reset", drive_sel_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(class_o == 3'd0 && volt_o == 2'd0, "R1 no result after reset", class_o, 0);

        foreach (VECS[i]) run_one(VECS[i], 1'b0);

        // R7: mid-run start and mode change ignored.
        pv = '{1'b1, 3'd5, 4'd4, 1'b0, 4'd0, 1'b0, 3'd2, 2'd1, 8'd20};
        run_one(pv, 1'b1);
        pv = '{1'b1, 3'd3, 4'd6, 1'b0, 4'd11, 1'b0, 3'd4, 2'd2, 8'd12};
        run_one(pv, 1'b1);

        // R1: reset during a measurement removes the drive and the result.
        @(negedge clk);
        quick_i = 1'b1; quick_secs_i = 3'd4; decade_i = 4'd3; open_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(drive_sel_o == 2'd0 && class_o == 3'd0, "R1 reset mid-run", drive_sel_o, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(done_o == 1'b0 && drive_sel_o == 2'd0, "R1 stays idle after reset",
            drive_sel_o, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule